// File: doc/BRIEF.md
# Slice-addressed register file

This block is a register file for a datapath that works through each wide word one narrow slice per cycle. It keeps a bank of words and offers two read ports and one write port. All three ports act on the same sub-word slice, picked by one shared slice-select input. Each read port returns that slice from its own addressed word with no clock of latency. The write port replaces that slice in one word on a rising clock edge.

Address zero is a constant-zero register: reads of it give zero from power-on onward, and writes to it are dropped. A write and a read of the same word in one cycle return the old contents; the new slice shows up only after the edge. A synchronous, active-high reset clears the bank, and a debug output exposes the whole bank as a packed array.

Top module: `slice_regfile`

## Requirements
- R1: With default parameters the bank holds 16 words of 32 bits, each split into 4 slices of 8 bits, where slice index k (the value of `slice_sel`) covers bits [8k+7:8k]; `bank_dbg[w]` shows word w.
- R2: Each read port i drives `rd_data[i]` with slice `slice_sel` of word `rd_addr[i]` in the same cycle the inputs are applied, with no clock of latency.
- R3: On a rising edge with `wr_en` high and `rst` low, `wr_data` replaces slice `slice_sel` of word `wr_addr`; every other slice of that word and every other word keeps its value.
- R4: On a rising edge with `wr_en` low, no stored bit changes, whatever the write address, data and select.
- R5: A write aimed at address 0 is dropped; `bank_dbg[0]` is zero at all times.
- R6: A read port whose address is 0 outputs zero at all times, including before the first reset and after attempted writes to address 0.
- R7: Reset is synchronous and active high: after a rising edge with `rst` high every word of `bank_dbg` is zero.
- R8: When `rst` and `wr_en` are both high on the same edge, the reset wins and no write is stored.
- R9: There is no bypass: a read of the word being written in the same cycle returns the value held before that edge, and the new slice appears on the next cycle.
- R10: The two read ports are independent: in one cycle they can read two different words and each returns its own word's slice.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| slice_sel | input | 2 | Slice index shared by all ports |
| rd_addr | input | 2x4 | Word address for each read port |
| rd_data | output | 2x8 | Selected slice for each read port |
| wr_en | input | 1 | Write enable |
| wr_addr | input | 4 | Word address of the write |
| wr_data | input | 8 | Slice value to write |
| bank_dbg | output | 16x32 | Whole bank, word w at index w |

## Verification
The two functions that meet in one cycle are a combinational read and a write to the same word and slice, and also a reset and a write on the same edge. The bench provokes the first by sweeping every nonzero word and slice with read port 0 pointed at the write address, expecting the pre-edge slice in that cycle and the new word on the debug output a cycle later. The second is provoked by asserting reset together with a write to a nonzero word and expecting that word, like all others, to be zero afterward.

// File: rtl/slrf_pkg.sv
package slrf_pkg;

    // Default geometry of the bank
    localparam int unsigned DEF_WORD_W  = 32;
    localparam int unsigned DEF_SLICE_W = 8;
    localparam int unsigned DEF_ADDR_W  = 4;
    localparam int unsigned DEF_N_RD    = 2;

    // Number of slices in a word
    function automatic int unsigned slices_per_word(int unsigned word_w, int unsigned slice_w);
        return word_w / slice_w;
    endfunction

    // Width of a select that names one slice (never zero)
    function automatic int unsigned sel_width(int unsigned n_slices);
        return (n_slices > 1) ? $clog2(n_slices) : 1;
    endfunction

    // Lowest bit of slice k
    function automatic int unsigned slice_lo(int unsigned k, int unsigned slice_w);
        return k * slice_w;
    endfunction

endpackage

// File: rtl/slrf_wdec.sv
module slrf_wdec
    import slrf_pkg::*;
#(
    parameter int unsigned ADDR_W     = DEF_ADDR_W,
    parameter int unsigned NUM_SLICES = 4,
    parameter int unsigned SEL_W      = sel_width(NUM_SLICES),
    localparam int unsigned NUM_WORDS = 1 << ADDR_W
) (
    input  logic                                   rst,
    input  logic                                   wr_en,
    input  logic [ADDR_W-1:0]                      wr_addr,
    input  logic [SEL_W-1:0]                       slice_sel,
    output logic [NUM_WORDS-1:0][NUM_SLICES-1:0]   hit
);

    logic go;

    // Reset has priority over any write
    assign go = wr_en && !rst;

    // Word 0 never receives a write enable
    assign hit[0] = '0;

    for (genvar w = 1; w < NUM_WORDS; w++) begin : g_word
        for (genvar s = 0; s < NUM_SLICES; s++) begin : g_slice
            assign hit[w][s] = go
                && (wr_addr == ADDR_W'(w))
                && (slice_sel == SEL_W'(s));
        end
    end

endmodule

// File: rtl/slrf_bank.sv
module slrf_bank
    import slrf_pkg::*;
#(
    parameter int unsigned WORD_W     = DEF_WORD_W,
    parameter int unsigned SLICE_W    = DEF_SLICE_W,
    parameter int unsigned ADDR_W     = DEF_ADDR_W,
    localparam int unsigned NUM_WORDS  = 1 << ADDR_W,
    localparam int unsigned NUM_SLICES = slices_per_word(WORD_W, SLICE_W)
) (
    input  logic                                  clk,
    input  logic                                  rst,
    input  logic [NUM_WORDS-1:0][NUM_SLICES-1:0]  hit,
    input  logic [SLICE_W-1:0]                    wr_data,
    output logic [NUM_WORDS-1:0][WORD_W-1:0]      bank
);

    // Word 0 has no storage: a constant zero
    assign bank[0] = '0;

    for (genvar w = 1; w < NUM_WORDS; w++) begin : g_word
        for (genvar s = 0; s < NUM_SLICES; s++) begin : g_slice
            logic [SLICE_W-1:0] q;

            always_ff @(posedge clk) begin
                if (rst) begin
                    q <= '0;
                end else if (hit[w][s]) begin
                    q <= wr_data;
                end
            end

            assign bank[w][slice_lo(s, SLICE_W) +: SLICE_W] = q;
        end
    end

endmodule

// File: rtl/slrf_rdport.sv
module slrf_rdport
    import slrf_pkg::*;
#(
    parameter int unsigned WORD_W     = DEF_WORD_W,
    parameter int unsigned SLICE_W    = DEF_SLICE_W,
    parameter int unsigned ADDR_W     = DEF_ADDR_W,
    localparam int unsigned NUM_WORDS  = 1 << ADDR_W,
    localparam int unsigned NUM_SLICES = slices_per_word(WORD_W, SLICE_W),
    localparam int unsigned SEL_W      = sel_width(NUM_SLICES)
) (
    input  logic [NUM_WORDS-1:0][WORD_W-1:0]  bank,
    input  logic [ADDR_W-1:0]                 addr,
    input  logic [SEL_W-1:0]                  slice_sel,
    output logic [SLICE_W-1:0]                data
);

    logic [WORD_W-1:0] word;

    assign word = bank[addr];

    // Address 0 is forced to zero here as well, independent of storage
    always_comb begin
        if (addr == '0) begin
            data = '0;
        end else begin
            data = word[slice_lo(int'(slice_sel), SLICE_W) +: SLICE_W];
        end
    end

endmodule

// File: rtl/slice_regfile.sv
module slice_regfile
    import slrf_pkg::*;
#(
    parameter int unsigned WORD_W  = DEF_WORD_W,
    parameter int unsigned SLICE_W = DEF_SLICE_W,
    parameter int unsigned ADDR_W  = DEF_ADDR_W,
    parameter int unsigned N_RD    = DEF_N_RD,
    localparam int unsigned NUM_WORDS  = 1 << ADDR_W,
    localparam int unsigned NUM_SLICES = slices_per_word(WORD_W, SLICE_W),
    localparam int unsigned SEL_W      = sel_width(NUM_SLICES)
) (
    input  logic                               clk,
    input  logic                               rst,
    input  logic [SEL_W-1:0]                   slice_sel,
    input  logic [N_RD-1:0][ADDR_W-1:0]        rd_addr,
    output logic [N_RD-1:0][SLICE_W-1:0]       rd_data,
    input  logic                               wr_en,
    input  logic [ADDR_W-1:0]                  wr_addr,
    input  logic [SLICE_W-1:0]                 wr_data,
    output logic [NUM_WORDS-1:0][WORD_W-1:0]   bank_dbg
);

    logic [NUM_WORDS-1:0][NUM_SLICES-1:0] wr_hit;
    logic [NUM_WORDS-1:0][WORD_W-1:0]     bank;

    slrf_wdec #(
        .ADDR_W     (ADDR_W),
        .NUM_SLICES (NUM_SLICES),
        .SEL_W      (SEL_W)
    ) u_wdec (
        .rst       (rst),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .slice_sel (slice_sel),
        .hit       (wr_hit)
    );

    slrf_bank #(
        .WORD_W  (WORD_W),
        .SLICE_W (SLICE_W),
        .ADDR_W  (ADDR_W)
    ) u_bank (
        .clk     (clk),
        .rst     (rst),
        .hit     (wr_hit),
        .wr_data (wr_data),
        .bank    (bank)
    );

    for (genvar p = 0; p < N_RD; p++) begin : g_rd
        slrf_rdport #(
            .WORD_W  (WORD_W),
            .SLICE_W (SLICE_W),
            .ADDR_W  (ADDR_W)
        ) u_rd (
            .bank      (bank),
            .addr      (rd_addr[p]),
            .slice_sel (slice_sel),
            .data      (rd_data[p])
        );
    end

    assign bank_dbg = bank;

endmodule

// File: rtl/slrf_checker.sv
module slrf_checker #(
    parameter int unsigned WORD_W     = 32,
    parameter int unsigned SLICE_W    = 8,
    parameter int unsigned ADDR_W     = 4,
    parameter int unsigned N_RD       = 2,
    parameter int unsigned NUM_SLICES = 4,
    parameter int unsigned SEL_W      = 2,
    localparam int unsigned NUM_WORDS = 1 << ADDR_W
) (
    input logic                               clk,
    input logic                               rst,
    input logic [SEL_W-1:0]                   slice_sel,
    input logic [N_RD-1:0][ADDR_W-1:0]        rd_addr,
    input logic [N_RD-1:0][SLICE_W-1:0]       rd_data,
    input logic                               wr_en,
    input logic [ADDR_W-1:0]                  wr_addr,
    input logic [SLICE_W-1:0]                 wr_data,
    input logic [NUM_WORDS-1:0][WORD_W-1:0]   bank_dbg,
    input logic [NUM_WORDS-1:0][NUM_SLICES-1:0] wr_hit
);

    // Record of the last accepted write, checked one edge later
    logic               lw_valid;
    logic [ADDR_W-1:0]  lw_addr;
    logic [SEL_W-1:0]   lw_sel;
    logic [SLICE_W-1:0] lw_data;

    always_ff @(posedge clk) begin
        if (rst) begin
            lw_valid <= 1'b0;
        end else begin
            lw_valid <= wr_en && (wr_addr != '0);
        end
        lw_addr <= wr_addr;
        lw_sel  <= slice_sel;
        lw_data <= wr_data;
    end

    // R3: the written slice holds the written data after the edge
    p_write_lands_r3: assert property (@(posedge clk) disable iff (rst)
        lw_valid |-> (bank_dbg[lw_addr][int'(lw_sel)*SLICE_W +: SLICE_W] == lw_data));

    // R3: at most one slice of one word is enabled for writing
    p_single_target_r3: assert property (@(posedge clk) disable iff (rst)
        $onehot0(wr_hit));

    // R4: without write enable the bank is unchanged at the next edge
    p_idle_stable_r4: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(bank_dbg));

    // R5: word 0 is always zero on the debug view
    p_word0_zero_r5: assert property (@(posedge clk) disable iff (rst)
        bank_dbg[0] == '0);

    // R7 and R8: an edge with reset leaves the whole bank zero
    p_reset_clears_r7: assert property (@(posedge clk)
        rst |=> (bank_dbg == '0));

    for (genvar p = 0; p < N_RD; p++) begin : g_port
        // R6: address 0 reads as zero
        p_addr0_reads_zero_r6: assert property (@(posedge clk) disable iff (rst)
            (rd_addr[p] == '0) |-> (rd_data[p] == '0));

        // R2 and R9: a nonzero read matches the currently held slice
        p_read_matches_bank_r2: assert property (@(posedge clk) disable iff (rst)
            (rd_addr[p] != '0) |->
                (rd_data[p] == bank_dbg[rd_addr[p]][int'(slice_sel)*SLICE_W +: SLICE_W]));
    end

endmodule

bind slice_regfile slrf_checker #(
    .WORD_W     (WORD_W),
    .SLICE_W    (SLICE_W),
    .ADDR_W     (ADDR_W),
    .N_RD       (N_RD),
    .NUM_SLICES (NUM_SLICES),
    .SEL_W      (SEL_W)
) u_slrf_checker (
    .clk       (clk),
    .rst       (rst),
    .slice_sel (slice_sel),
    .rd_addr   (rd_addr),
    .rd_data   (rd_data),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .bank_dbg  (bank_dbg),
    .wr_hit    (wr_hit)
);

// File: tb/slice_regfile_bench.sv
`timescale 1ns/1ps
module slice_regfile_bench;

    localparam int WW = 32;
    localparam int SW = 8;
    localparam int AW = 4;
    localparam int NW = 16;

    logic                   clk = 1'b0;
    logic                   rst = 1'b0;
    logic [1:0]             slice_sel = '0;
    logic [1:0][AW-1:0]     rd_addr = '0;
    logic [1:0][SW-1:0]     rd_data;
    logic                   wr_en = 1'b0;
    logic [AW-1:0]          wr_addr = '0;
    logic [SW-1:0]          wr_data = '0;
    logic [NW-1:0][WW-1:0]  bank_dbg;

    always #2.5 clk = ~clk;

    slice_regfile u_slice_regfile (
        .clk       (clk),
        .rst       (rst),
        .slice_sel (slice_sel),
        .rd_addr   (rd_addr),
        .rd_data   (rd_data),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .bank_dbg  (bank_dbg)
    );

    typedef struct {
        int          kind;   // 0: read port, 1: debug word
        int          idx;
        logic [31:0] exp;
        string       req;
    } item_t;

    item_t       sb[$];
    logic [31:0] model [NW];
    int          checks = 0;
    int          errors = 0;
    bit          done   = 1'b0;

    // Driver: apply one cycle of stimulus and queue what must be seen in it
    task automatic step(bit r, bit we, int wa, int sel, int wd, int a0, int a1,
                        bit chk_rd, string tag_rd, int dbg_word, string tag_dbg);
        item_t it;
        @(negedge clk);
        rst       = r;
        wr_en     = we;
        wr_addr   = AW'(wa);
        slice_sel = 2'(sel);
        wr_data   = SW'(wd);
        rd_addr[0] = AW'(a0);
        rd_addr[1] = AW'(a1);
        if (chk_rd) begin
            it.kind = 0; it.idx = 0; it.req = tag_rd;
            it.exp  = (a0 == 0) ? 32'h0 : 32'(model[a0][sel*8 +: 8]);
            sb.push_back(it);
            it.idx = 1;
            it.exp = (a1 == 0) ? 32'h0 : 32'(model[a1][sel*8 +: 8]);
            sb.push_back(it);
        end
        if (dbg_word >= 0) begin
            it.kind = 1; it.idx = dbg_word; it.req = tag_dbg;
            it.exp  = model[dbg_word];
            sb.push_back(it);
        end
        // Effect of the coming edge on the reference model
        if (r) begin
            for (int i = 0; i < NW; i++) model[i] = '0;
        end else if (we && wa != 0) begin
            model[wa][sel*8 +: 8] = 8'(wd);
        end
    endtask

    // Monitor: compare queued items once the cycle's inputs have settled
    initial begin
        item_t it;
        logic [31:0] act;
        forever begin
            @(negedge clk);
            #1;
            while (sb.size() > 0) begin
                it = sb.pop_front();
                if (it.kind == 0) act = 32'(rd_data[it.idx]);
                else              act = bank_dbg[it.idx];
                checks++;
                if (act !== it.exp) begin
                    errors++;
                    $display("FAIL %s kind=%0d idx=%0d actual=%h expected=%h",
                             it.req, it.kind, it.idx, act, it.exp);
                end
            end
        end
    end

    // Watchdog
    initial begin
        #(200000 * 5);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < NW; i++) model[i] = '0;

        // R6: before any reset, address 0 reads zero, even with a write to it
        step(0, 1, 0, 2, 8'h5A, 0, 0, 1, "R6", -1, "");
        step(0, 1, 0, 3, 8'hFF, 0, 0, 1, "R6", -1, "");

        // R8: reset together with a write to word 5; reset wins
        step(1, 1, 5, 1, 8'hAA, 0, 0, 1, "R6", -1, "");

        // R7: every word is zero after the reset edge
        for (int w = 0; w < NW; w++)
            step(0, 0, 0, 0, 0, w, 15 - w, 1, "R7", w, (w == 5) ? "R8" : "R7");

        // R3, R9: write every slice of every nonzero word, reading the same word
        for (int w = 1; w < NW; w++) begin
            for (int s = 0; s < 4; s++) begin
                step(0, 1, w, s, (w * 16 + s * 5 + 3) & 8'hFF,
                     w, (w + 7) % NW, 1, "R9", w, "R3");
            end
        end

        // R1: slice placement, visible on the debug view of each word
        for (int w = 0; w < NW; w++)
            step(0, 0, 0, 0, 0, 0, 0, 0, "", w, "R1");

        // R2, R10, R4: read sweep with write data present but enable low
        for (int a = 0; a < NW; a++) begin
            for (int s = 0; s < 4; s++) begin
                step(0, 0, a, s, 8'hC3, a, 15 - a, 1, "R10", a, "R4");
            end
        end

        // R2: overwrite one slice, then confirm only that slice moved
        step(0, 1, 9, 2, 8'h11, 3, 12, 1, "R2", 9, "R3");
        step(0, 0, 0, 2, 0, 9, 9, 1, "R2", 9, "R3");
        step(0, 0, 0, 1, 0, 9, 8, 1, "R2", 9, "R3");

        // R5: attempted writes to address 0 on every slice
        for (int s = 0; s < 4; s++)
            step(0, 1, 0, s, 8'hEE, 0, 1, 1, "R6", 0, "R5");
        step(0, 0, 0, 0, 0, 0, 0, 1, "R6", 0, "R5");

        // R7: final reset clears all words
        step(1, 0, 0, 0, 0, 0, 0, 0, "", -1, "");
        for (int w = 0; w < NW; w++)
            step(0, 0, 0, 3, 0, w, w, 1, "R7", w, "R7");

        @(negedge clk);
        #2;
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule